// File: doc/BRIEF.md
# Indirect Shared Register Access Bridge

This bridge lets a host reach a bank of internal shared registers through only two host-visible registers: a control register at host offset 0x0EC and a data register at host offset 0x0F4. The main processor domain does not need to be powered for this to work. A single write to the control register chooses the 16-bit target offset and the access type. That same write starts the internal access. The bridge then performs exactly one read or one write on an internal request/acknowledge register bus.

To write a shared register, the host first loads the data register. It then writes the control register with the offset in bits 15:0 and the value 3 in bits 29:28. To read a shared register, the host writes the control register with the offset and the value 2 in bits 29:28. It polls the busy flag in control bit 31 and then reads the result from the data register. An access that is never acknowledged is abandoned after a parameterised number of cycles. In that case the data register reads all ones and a sticky error flag is raised.

The sequencer has three states:
- ST_IDLE: no access is outstanding. A launching control write moves it to ST_WAIT.
- ST_WAIT: the request is held on the internal bus. An acknowledge returns it to ST_IDLE. Reaching the cycle limit without an acknowledge moves it to ST_ABORT.
- ST_ABORT: lasts one cycle. It records the failure and then returns to ST_IDLE.

Top module: `shreg_bridge`

## Requirements
- R1: After reset the control register and the data register both read 0, and `bus_req` is low.
- R2: A host write to 0x0F4 loads the data register. A control write (to 0x0EC) with bits 29:28 = 3 starts an internal write: `bus_req` rises one cycle later with `bus_we`=1, `bus_addr` = control bits 15:0 and `bus_wdata` = the data register.
- R3: A control write with bits 29:28 = 2 starts an internal read at offset bits 15:0 with `bus_we`=0. When `bus_ack` is seen, `bus_rdata` is placed in the data register.
- R4: A control write with bits 29:28 = 0 or 1 is stored and reads back from the control register, but it raises no `bus_req` and leaves the data register unchanged.
- R5: Control bit 31 (busy) reads 1 from the cycle after a launch until the access ends. While `bus_req` is high, `bus_addr` stays stable, and `bus_req` drops only after an acknowledge or on abort.
- R6: While busy, host writes to the control register and to the data register are ignored.
- R7: If no `bus_ack` arrives within TIMEOUT request cycles, the access is abandoned. The data register then reads 0xFFFFFFFF, control bit 30 (error) is set, and busy clears TIMEOUT+1 cycles after the launch.
- R8: The error flag stays set through data writes and non-launching control writes. It is cleared by the next launched access.
- R9: The control register reads back as {busy[31], error[30], type[29:28], zeros[27:16], offset[15:0]}. Host reads of any other address, or with `host_rd` low, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HADDR_W (12) | Host byte address |
| host_wdata | input | DATA_W (32) | Host write data |
| host_rdata | output | DATA_W (32) | Host read data, combinational |
| bus_req | output | 1 | Internal access request, held until acknowledged or abandoned |
| bus_we | output | 1 | Internal access is a write |
| bus_addr | output | OFS_W (16) | Internal target offset |
| bus_wdata | output | DATA_W (32) | Internal write data |
| bus_rdata | input | DATA_W (32) | Internal read data, valid with ack |
| bus_ack | input | 1 | Internal acknowledge, one cycle |

## Verification
The hardest situations to reach from the ports are host writes that arrive while an access is still outstanding, and the abandoned access.

For the first, the testbench's shared-register model delays its acknowledge by a number of cycles taken from the two low offset bits. Targeting an offset with the longest delay leaves a window in which the stray control and data writes are issued.

For the second, the model never acknowledges offsets with bit 15 set. This drives the bridge into its abort path. The bench then counts the cycles until busy clears and checks that the error flag survives later non-launching writes.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    localparam logic [11:0] SBR_CTRL_ADDR = 12'h0EC;
    localparam logic [11:0] SBR_DATA_ADDR = 12'h0F4;

    localparam int SBR_BUSY_BIT = 31;
    localparam int SBR_ERR_BIT  = 30;
    localparam int SBR_TYPE_HI  = 29;
    localparam int SBR_TYPE_LO  = 28;

    typedef enum logic [1:0] {
        OP_NONE0 = 2'd0,
        OP_NONE1 = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } sbr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ABORT = 2'd2
    } sbr_state_e;
endpackage

// File: rtl/sbr_host_regs.sv
module sbr_host_regs
    import sbr_pkg::*;
#(
    parameter int HADDR_W = 12,
    parameter int DATA_W  = 32,
    parameter int OFS_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               busy,
    input  logic               rd_done,
    input  logic [DATA_W-1:0]  rd_value,
    input  logic               abort,
    output logic               launch,
    output logic               launch_we,
    output logic [OFS_W-1:0]   launch_ofs,
    output logic [DATA_W-1:0]  data_q
);
    localparam int PAD_W = DATA_W - 4 - OFS_W;

    logic [OFS_W-1:0] ofs_q;
    sbr_op_e          type_q;
    logic             err_q;
    logic             sel_ctrl;
    logic             sel_data;
    logic             wr_ctrl;
    logic             wr_data;
    logic [DATA_W-1:0] ctrl_view;

    assign sel_ctrl = (host_addr == HADDR_W'(SBR_CTRL_ADDR));
    assign sel_data = (host_addr == HADDR_W'(SBR_DATA_ADDR));
    assign wr_ctrl  = host_wr && sel_ctrl && !busy;
    assign wr_data  = host_wr && sel_data && !busy;

    assign launch     = wr_ctrl && host_wdata[SBR_TYPE_HI];
    assign launch_we  = host_wdata[SBR_TYPE_LO];
    assign launch_ofs = host_wdata[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            type_q <= OP_NONE0;
        end else if (wr_ctrl) begin
            ofs_q  <= host_wdata[OFS_W-1:0];
            type_q <= sbr_op_e'(host_wdata[SBR_TYPE_HI:SBR_TYPE_LO]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (abort) begin
            err_q <= 1'b1;
        end else if (launch) begin
            err_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (abort) begin
            data_q <= '1;
        end else if (rd_done) begin
            data_q <= rd_value;
        end else if (wr_data) begin
            data_q <= host_wdata;
        end
    end

    assign ctrl_view = {busy, err_q, type_q, {PAD_W{1'b0}}, ofs_q};

    always_comb begin
        host_rdata = '0;
        if (host_rd && sel_ctrl) begin
            host_rdata = ctrl_view;
        end else if (host_rd && sel_data) begin
            host_rdata = data_q;
        end
    end

    // R6
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel_ctrl && busy) |=> ($stable(ofs_q) && $stable(type_q)));

    // R7
    err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (data_q == '1));

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !abort) |=> !err_q);
endmodule

// File: rtl/sbr_seq.sv
module sbr_seq
    import sbr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int OFS_W   = 16,
    parameter int TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_we,
    input  logic [OFS_W-1:0]  launch_ofs,
    input  logic [DATA_W-1:0] launch_data,
    input  logic              bus_ack,
    output logic              busy,
    output logic              rd_done,
    output logic              abort,
    output logic              bus_req,
    output logic              bus_we,
    output logic [OFS_W-1:0]  bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    sbr_state_e       state;
    sbr_state_e       nxt;
    logic [CNT_W-1:0] cnt;
    logic             limit_hit;
    logic             we_q;
    logic [OFS_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign limit_hit = (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (launch) nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (bus_ack)        nxt = ST_IDLE;
                else if (limit_hit) nxt = ST_ABORT;
            end
            ST_ABORT: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            cnt     <= '0;
        end else begin
            if (state == ST_IDLE && launch) begin
                we_q    <= launch_we;
                addr_q  <= launch_ofs;
                wdata_q <= launch_data;
            end
            if (state == ST_WAIT && !bus_ack && !limit_hit) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        busy      = 1'b0;
        rd_done   = 1'b0;
        abort     = 1'b0;
        bus_we    = we_q;
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
        unique case (state)
            ST_IDLE: begin
            end
            ST_WAIT: begin
                bus_req = 1'b1;
                busy    = 1'b1;
                rd_done = bus_ack && !we_q;
            end
            ST_ABORT: begin
                busy  = 1'b1;
                abort = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R2
    launch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !busy) |=> bus_req);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_we)));

    // R5
    req_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> ($past(bus_ack) || abort));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);
endmodule

// File: rtl/shreg_bridge.sv
module shreg_bridge
    import sbr_pkg::*;
#(
    parameter int HADDR_W = 12,
    parameter int DATA_W  = 32,
    parameter int OFS_W   = 16,
    parameter int TIMEOUT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [OFS_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_ack
);
    logic              busy;
    logic              rd_done;
    logic              abort;
    logic              launch;
    logic              launch_we;
    logic [OFS_W-1:0]  launch_ofs;
    logic [DATA_W-1:0] data_q;

    sbr_host_regs #(
        .HADDR_W (HADDR_W),
        .DATA_W  (DATA_W),
        .OFS_W   (OFS_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .rd_done    (rd_done),
        .rd_value   (bus_rdata),
        .abort      (abort),
        .launch     (launch),
        .launch_we  (launch_we),
        .launch_ofs (launch_ofs),
        .data_q     (data_q)
    );

    sbr_seq #(
        .DATA_W  (DATA_W),
        .OFS_W   (OFS_W),
        .TIMEOUT (TIMEOUT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_we   (launch_we),
        .launch_ofs  (launch_ofs),
        .launch_data (data_q),
        .bus_ack     (bus_ack),
        .busy        (busy),
        .rd_done     (rd_done),
        .abort       (abort),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !bus_req);
endmodule

// File: tb/tb_shreg_bridge.sv
module tb_shreg_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 8;
    localparam logic [11:0] A_CTRL = 12'h0EC;
    localparam logic [11:0] A_DATA = 12'h0F4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        bus_req;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shreg_bridge #(.TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // shared register model: ack delay = addr[1:0], offsets with bit 15 never ack
    logic [31:0] mem [16];
    logic [3:0]  dcnt;
    logic        req_d;
    int          req_starts;
    logic        last_we;
    logic [15:0] last_addr;
    logic [31:0] last_wdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            dcnt      <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= 32'hC0DE0000 + i;
        end else if (bus_req && !bus_ack && !bus_addr[15]) begin
            if (dcnt == {2'b00, bus_addr[1:0]}) begin
                bus_ack <= 1'b1;
                dcnt    <= '0;
                if (bus_we) mem[bus_addr[3:0]] <= bus_wdata;
                else        bus_rdata <= mem[bus_addr[3:0]];
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end else begin
            bus_ack <= 1'b0;
            if (!bus_req) dcnt <= '0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            req_d      <= 1'b0;
            req_starts <= 0;
        end else begin
            req_d <= bus_req;
            if (bus_req && !req_d) begin
                req_starts <= req_starts + 1;
                last_we    <= bus_we;
                last_addr  <= bus_addr;
                last_wdata <= bus_wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [31:0] d);
        host_rd = 1'b1; host_addr = a;
        #1;
        d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        hread(A_CTRL, v);
        while (v[31] && n < 50) begin
            @(negedge clk);
            n++;
            hread(A_CTRL, v);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] d0;
        int n;
        int base;

        repeat (3) @(negedge clk);
        // R1 reset state
        hread(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        hread(A_DATA, v); chk("R1 data", v, 32'h0);
        chk("R1 req", {31'b0, bus_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 read sweep over initial contents
        for (int i = 0; i < 16; i++) begin
            hwrite(A_CTRL, 32'h2000_0000 | i);
            wait_idle(n);
            hread(A_DATA, v);
            chk("R3 read data", v, 32'hC0DE0000 + i);
            chk("R3 bus_we", {31'b0, last_we}, 32'h0);
            chk("R3 bus_addr", {16'b0, last_addr}, i);
        end
        // R9 control readback format
        hread(A_CTRL, v); chk("R9 ctrl view", v, 32'h2000_000F);

        // R2 write sweep then readback
        for (int i = 0; i < 16; i++) begin
            hwrite(A_DATA, (i * 32'h1111_1111) ^ 32'h5A5A_0000);
            hwrite(A_CTRL, 32'h3000_0000 | i);
            wait_idle(n);
            chk("R2 bus_we", {31'b0, last_we}, 32'h1);
            chk("R2 bus_addr", {16'b0, last_addr}, i);
            chk("R2 bus_wdata", last_wdata, (i * 32'h1111_1111) ^ 32'h5A5A_0000);
        end
        for (int i = 0; i < 16; i++) begin
            hwrite(A_CTRL, 32'h2000_0000 | i);
            wait_idle(n);
            hread(A_DATA, v);
            chk("R2 readback", v, (i * 32'h1111_1111) ^ 32'h5A5A_0000);
        end

        // R4 types 0 and 1 launch nothing
        hread(A_DATA, d0);
        base = req_starts;
        hwrite(A_CTRL, 32'h0000_0ABC);
        repeat (4) @(negedge clk);
        hread(A_CTRL, v); chk("R4 type0 stored", v, 32'h0000_0ABC);
        hwrite(A_CTRL, 32'h1000_1234);
        repeat (4) @(negedge clk);
        hread(A_CTRL, v); chk("R4 type1 stored", v, 32'h1000_1234);
        chk("R4 no request", req_starts, base);
        hread(A_DATA, v); chk("R4 data kept", v, d0);

        // R5 / R6 busy window with slowest ack
        hwrite(A_DATA, 32'h0BAD_F00D);
        base = req_starts;
        hwrite(A_CTRL, 32'h3000_0003);
        hread(A_CTRL, v); chk("R5 busy set", {31'b0, v[31]}, 32'h1);
        hwrite(A_CTRL, 32'h2000_0007);
        hwrite(A_DATA, 32'hDEAD_BEEF);
        wait_idle(n);
        hread(A_CTRL, v); chk("R6 ctrl ignored", v, 32'h3000_0003);
        hread(A_DATA, v); chk("R6 data ignored", v, 32'h0BAD_F00D);
        chk("R6 one request", req_starts, base + 1);
        hwrite(A_CTRL, 32'h2000_0003);
        wait_idle(n);
        hread(A_DATA, v); chk("R6 target written", v, 32'h0BAD_F00D);

        // R7 timeout on an offset that never acks
        hwrite(A_CTRL, 32'h2000_8000);
        wait_idle(n);
        chk("R7 abort latency", n, TMO + 1);
        hread(A_DATA, v); chk("R7 data all ones", v, 32'hFFFF_FFFF);
        hread(A_CTRL, v); chk("R7 ctrl err", v, 32'h6000_8000);

        // R8 error sticky through non-launching writes, cleared by launch
        hwrite(A_DATA, 32'h1234_5678);
        hwrite(A_CTRL, 32'h1000_0005);
        hread(A_CTRL, v); chk("R8 err sticky", v, 32'h5000_0005);
        hwrite(A_CTRL, 32'h2000_0005);
        hread(A_CTRL, v); chk("R8 err cleared", {30'b0, v[31:30]}, 32'h2);
        wait_idle(n);
        hread(A_DATA, v); chk("R8 read after error", v, (5 * 32'h1111_1111) ^ 32'h5A5A_0000);

        // R7 timeout on a write also raises error
        hwrite(A_CTRL, 32'h3000_8001);
        wait_idle(n);
        hread(A_CTRL, v); chk("R7 write abort err", v, 32'h7000_8001);

        // R9 other addresses and no strobe read zero
        hread(12'h000, v); chk("R9 other addr", v, 32'h0);
        hread(12'h0F0, v); chk("R9 gap addr", v, 32'h0);
        host_addr = A_CTRL; host_rd = 1'b0; #1;
        chk("R9 no strobe", host_rdata, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule